// File: doc/BRIEF.md
# Battery-Backed Domain Control Register

This block is a single 32-bit control and status register that lives in a battery-backed clock domain. It holds the enable and bypass controls of the low-speed external oscillator, a selector for the clock that drives the real-time clock, an enable for that clock, and a software reset for the whole domain. A bus master reads and writes it through a word-addressed port with byte enables. A `bus_ready` handshake adds wait states when one access to the register follows another with no idle cycle between them.

The domain fields are protected. They change only while the power controller raises `wp_release`. The source selector can be written once and then stays fixed until the domain is reset. The bypass control accepts writes only while the oscillator is switched off. Only the domain reset input or the software reset bit clears these fields. The system reset affects the bus handshake alone.

A small tick selector turns the chosen clock source into a one-cycle RTC tick enable. The sources are the low-speed external tick, the low-speed internal tick, or one pulse for every 128 high-speed ticks. The RTC enable bit gates the result.

Top module: `bkd_ctrl`

## Requirements
- R1: `rst_bkd_n` low clears every field, so all outputs are 0 and a read returns 0. Pulsing `rst_sys_n` leaves every field and output unchanged.
- R2: A read at byte offset 0x20 (address bits [1:0] ignored) returns: bit 0 oscillator enable, bit 1 ready flag, bit 2 bypass, bits 9:8 source select, bit 15 RTC enable, bit 16 software reset. Every other bit reads 0. Any other offset reads 0 and ignores writes.
- R3: While `wp_release` is low, writes leave the enable, bypass, source-select and RTC-enable fields unchanged.
- R4: Once the source select is nonzero, later writes to it are ignored until a domain reset clears it.
- R5: A write to the bypass bit takes effect only when the stored oscillator enable is 0 just before that write.
- R6: The software reset bit (bit 16) is written through byte lane 2 whatever the state of `wp_release`. While it is 1, the next clock clears the four protected fields, they stay 0, and writes to them have no effect. `dom_rst_o` shows the bit.
- R7: The ready flag (bit 1) equals `osc_rdy_in` delayed through a two-flop synchronizer, ANDed with the oscillator enable. Its first read shows 0 and the read one cycle later shows 1 after the input rises. Writes to it do nothing.
- R8: An access to the register that starts in the cycle right after a completed access to it sees `bus_ready` low for 2 cycles. Any other access, including one to an unmapped offset, is ready at once.
- R9: Byte lane 0 writes bits 2:0, lane 1 writes bits 15:8 and lane 2 writes bit 16. A field is written only when its lane enable is set.
- R10: Source codes are 0 = none, 1 = low-speed external tick, 2 = low-speed internal tick, 3 = high-speed tick divided by 128. `rtc_tick_o` follows the selected source one cycle later. Unselected sources are ignored. With code 3 and a high-speed tick every cycle, ticks come exactly 128 cycles apart.
- R11: While the RTC enable is 0, `rtc_tick_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and domain logic |
| rst_sys_n | input | 1 | System reset, active low; resets only the bus handshake |
| rst_bkd_n | input | 1 | Domain reset, active low; clears all fields |
| bus_sel | input | 1 | Access request, held until `bus_ready` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables |
| bus_rdata | output | 32 | Read data, valid while selected |
| bus_ready | output | 1 | Access completes on a clock edge where this is high |
| wp_release | input | 1 | Write-protect release from the power controller |
| osc_rdy_in | input | 1 | Asynchronous oscillator-ready status |
| hs_tick_in | input | 1 | High-speed oscillator tick enable |
| ls_ext_tick_in | input | 1 | Low-speed external oscillator tick enable |
| ls_int_tick_in | input | 1 | Low-speed internal oscillator tick enable |
| osc_en_o | output | 1 | Low-speed external oscillator enable |
| osc_byp_o | output | 1 | Oscillator bypass |
| rtc_src_o | output | 2 | RTC source select |
| rtc_en_o | output | 1 | RTC clock enable |
| dom_rst_o | output | 1 | Software domain reset bit |
| rtc_tick_o | output | 1 | Selected, gated RTC tick enable |

## Verification
The bus properties assume that a master holds `bus_sel`, the address and the data steady from the start of an access until the edge where `bus_ready` is high, and keeps the bus idle while `rst_sys_n` is low. The ready-flag checks assume that `osc_rdy_in` stays steady for at least three cycles before a read is compared. The stimulus drives every input on the falling edge, holds each access until it completes, and inserts idle cycles around resets and after setting the software reset bit. It changes `osc_rdy_in` only in the synchronizer-latency test, where the read data is sampled cycle by cycle.

// File: rtl/bkd_pkg.sv
`timescale 1ns/1ps
package bkd_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned POS_EN    = 0;
  localparam int unsigned POS_RDY   = 1;
  localparam int unsigned POS_BYP   = 2;
  localparam int unsigned POS_SRC   = 8;
  localparam int unsigned POS_RTCEN = 15;
  localparam int unsigned POS_SWRST = 16;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'b00,
    SRC_LS_EXT = 2'b01,
    SRC_LS_INT = 2'b10,
    SRC_HS_DIV = 2'b11
  } rtc_src_e;

  typedef struct packed {
    logic     swrst;
    logic     rtc_en;
    rtc_src_e src;
    logic     byp;
    logic     rdy;
    logic     en;
  } bkd_img_t;

  // Place the fields into the 32-bit read image; all other bits stay 0.
  function automatic logic [REG_W-1:0] pack_image(input bkd_img_t f);
    logic [REG_W-1:0] w;
    w = '0;
    w[POS_EN]       = f.en;
    w[POS_RDY]      = f.rdy;
    w[POS_BYP]      = f.byp;
    w[POS_SRC +: 2] = f.src;
    w[POS_RTCEN]    = f.rtc_en;
    w[POS_SWRST]    = f.swrst;
    return w;
  endfunction

  // Byte lane that carries a given bit position.
  function automatic logic lane_on(input logic [3:0] be, input int unsigned pos);
    return be[pos / 8];
  endfunction

  // The selector accepts a value only while still empty.
  function automatic logic src_open(input rtc_src_e cur);
    return cur == SRC_NONE;
  endfunction

  // Pick the tick for the chosen source.
  function automatic logic pick_tick(input rtc_src_e s, input logic t_ext,
                                     input logic t_int, input logic t_div);
    case (s)
      SRC_LS_EXT: return t_ext;
      SRC_LS_INT: return t_int;
      SRC_HS_DIV: return t_div;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bkd_bus_wait.sv
`timescale 1ns/1ps
module bkd_bus_wait #(
  parameter int unsigned WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_sel,
  input  logic acc_hit,
  output logic ready,
  output logic acc_done,
  output logic wait_start
);
  generate
    if (WAIT_CYC == 0) begin : g_nowait
      logic unused_nw;
      assign unused_nw  = clk ^ rst_n;
      assign ready      = acc_sel;
      assign acc_done   = acc_sel && acc_hit;
      assign wait_start = 1'b0;
    end else begin : g_wait
      localparam int unsigned CW = $clog2(WAIT_CYC + 1);
      logic          done_q;
      logic          in_wait;
      logic [CW-1:0] wcnt;
      logic          hold;

      // Back-to-back hit: previous cycle completed an access to this register.
      assign wait_start = acc_sel && acc_hit && done_q && !in_wait;
      assign hold       = in_wait && (wcnt != '0);
      assign ready      = acc_sel && !wait_start && !hold;
      assign acc_done   = ready && acc_hit;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          done_q  <= 1'b0;
          in_wait <= 1'b0;
          wcnt    <= '0;
        end else begin
          done_q <= acc_done;
          if (wait_start) begin
            in_wait <= 1'b1;
            wcnt    <= CW'(WAIT_CYC - 1);
          end else if (hold) begin
            wcnt <= wcnt - 1'b1;
          end else if (acc_done) begin
            in_wait <= 1'b0;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bkd_fields.sv
`timescale 1ns/1ps
module bkd_fields
  import bkd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic        wp_release,
  input  logic        osc_rdy_async,
  output bkd_img_t    img
);
  logic                   en_q;
  logic                   byp_q;
  logic                   rtcen_q;
  logic                   swrst_q;
  rtc_src_e               src_q;
  logic [SYNC_STAGES-1:0] sync_q;

  logic wr_lo;
  logic wr_mid;
  logic wr_rst;
  logic unused_wdata;

  assign wr_lo  = wr_en && lane_on(be, POS_EN) && wp_release;
  assign wr_mid = wr_en && lane_on(be, POS_RTCEN) && wp_release;
  assign wr_rst = wr_en && lane_on(be, POS_SWRST);

  assign unused_wdata = ^{wdata[31:17], wdata[14:10], wdata[7:3], wdata[POS_RDY], be[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      byp_q   <= 1'b0;
      rtcen_q <= 1'b0;
      swrst_q <= 1'b0;
      src_q   <= SRC_NONE;
      sync_q  <= '0;
    end else begin
      sync_q <= (sync_q << 1) | SYNC_STAGES'(osc_rdy_async);
      if (swrst_q) begin
        en_q    <= 1'b0;
        byp_q   <= 1'b0;
        rtcen_q <= 1'b0;
        src_q   <= SRC_NONE;
      end else begin
        if (wr_lo) begin
          en_q <= wdata[POS_EN];
          if (!en_q) byp_q <= wdata[POS_BYP];
        end
        if (wr_mid) begin
          rtcen_q <= wdata[POS_RTCEN];
          if (src_open(src_q)) src_q <= rtc_src_e'(wdata[POS_SRC +: 2]);
        end
      end
      if (wr_rst) swrst_q <= wdata[POS_SWRST];
    end
  end

  assign img.en     = en_q;
  assign img.rdy    = sync_q[SYNC_STAGES-1] & en_q;
  assign img.byp    = byp_q;
  assign img.src    = src_q;
  assign img.rtc_en = rtcen_q;
  assign img.swrst  = swrst_q;
endmodule

// File: rtl/bkd_tick_sel.sv
`timescale 1ns/1ps
module bkd_tick_sel
  import bkd_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     hs_tick,
  input  logic     ls_ext_tick,
  input  logic     ls_int_tick,
  input  rtc_src_e src,
  input  logic     rtc_en,
  output logic     tick_o,
  output logic     div_pulse
);
  logic [DIV_W-1:0] div_q;

  assign div_pulse = hs_tick && (div_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      if (hs_tick) div_q <= div_q + 1'b1;
      tick_o <= rtc_en && pick_tick(src, ls_ext_tick, ls_int_tick, div_pulse);
    end
  end
endmodule

// File: rtl/bkd_ctrl.sv
`timescale 1ns/1ps
module bkd_ctrl
  import bkd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned REG_OFFSET  = 32'h20,
  parameter int unsigned WAIT_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_W       = 7
) (
  input  logic              clk,
  input  logic              rst_sys_n,
  input  logic              rst_bkd_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic              wp_release,
  input  logic              osc_rdy_in,
  input  logic              hs_tick_in,
  input  logic              ls_ext_tick_in,
  input  logic              ls_int_tick_in,
  output logic              osc_en_o,
  output logic              osc_byp_o,
  output logic [1:0]        rtc_src_o,
  output logic              rtc_en_o,
  output logic              dom_rst_o,
  output logic              rtc_tick_o
);
  localparam int unsigned        WORD_W   = ADDR_W - 2;
  localparam logic [WORD_W-1:0]  REG_WORD = WORD_W'(REG_OFFSET >> 2);

  logic     acc_hit;
  logic     acc_done;
  logic     wait_start;
  logic     wr_en;
  logic     div_pulse;
  logic     unused_top;
  bkd_img_t img;

  assign acc_hit    = bus_sel && (bus_addr[ADDR_W-1:2] == REG_WORD);
  assign wr_en      = acc_done && bus_wr;
  assign unused_top = ^bus_addr[1:0];

  bkd_bus_wait #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk        (clk),
    .rst_n      (rst_sys_n),
    .acc_sel    (bus_sel),
    .acc_hit    (acc_hit),
    .ready      (bus_ready),
    .acc_done   (acc_done),
    .wait_start (wait_start)
  );

  bkd_fields #(.SYNC_STAGES(SYNC_STAGES)) u_fields (
    .clk           (clk),
    .rst_n         (rst_bkd_n),
    .wr_en         (wr_en),
    .wdata         (bus_wdata),
    .be            (bus_be),
    .wp_release    (wp_release),
    .osc_rdy_async (osc_rdy_in),
    .img           (img)
  );

  bkd_tick_sel #(.DIV_W(DIV_W)) u_tick (
    .clk         (clk),
    .rst_n       (rst_bkd_n),
    .hs_tick     (hs_tick_in),
    .ls_ext_tick (ls_ext_tick_in),
    .ls_int_tick (ls_int_tick_in),
    .src         (img.src),
    .rtc_en      (img.rtc_en),
    .tick_o      (rtc_tick_o),
    .div_pulse   (div_pulse)
  );

  assign bus_rdata = acc_hit ? pack_image(img) : '0;
  assign osc_en_o  = img.en;
  assign osc_byp_o = img.byp;
  assign rtc_src_o = img.src;
  assign rtc_en_o  = img.rtc_en;
  assign dom_rst_o = img.swrst;
endmodule

// File: rtl/bkd_ctrl_chk.sv
`timescale 1ns/1ps
module bkd_ctrl_chk (
  input logic        clk,
  input logic        rst_sys_n,
  input logic        rst_bkd_n,
  input logic        wp_release,
  input logic        bus_ready,
  input logic        acc_hit,
  input logic        acc_done,
  input logic        wait_start,
  input logic        div_pulse,
  input logic [31:0] bus_rdata,
  input logic        osc_en_o,
  input logic        osc_byp_o,
  input logic [1:0]  rtc_src_o,
  input logic        rtc_en_o,
  input logic        dom_rst_o,
  input logic        rtc_tick_o
);
  localparam logic [31:0] RSV_MASK = 32'hFFFE_7CF8;

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_bkd_n)
    acc_hit |-> ((bus_rdata & RSV_MASK) == 32'h0));

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_bkd_n)
    !acc_hit |-> (bus_rdata == 32'h0));

  p_wp_lock_r3: assert property (@(posedge clk) disable iff (!rst_bkd_n)
    (!wp_release && !dom_rst_o) |=> $stable({osc_en_o, osc_byp_o, rtc_src_o, rtc_en_o}));

  p_src_once_r4: assert property (@(posedge clk) disable iff (!rst_bkd_n)
    (rtc_src_o != 2'b00 && !dom_rst_o) |=> (rtc_src_o == $past(rtc_src_o)));

  p_byp_hold_r5: assert property (@(posedge clk) disable iff (!rst_bkd_n)
    (osc_en_o && !dom_rst_o) |=> $stable(osc_byp_o));

  p_swrst_clear_r6: assert property (@(posedge clk) disable iff (!rst_bkd_n)
    dom_rst_o |=> (!osc_en_o && !osc_byp_o && rtc_src_o == 2'b00 && !rtc_en_o));

  p_rdy_gate_r7: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_bkd_n)
    (acc_hit && !osc_en_o) |-> !bus_rdata[1]);

  p_b2b_wait_r8: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (acc_hit && $past(acc_done)) |-> !bus_ready);

  p_wait_cause_r8: assert property (@(posedge clk) disable iff (!rst_sys_n)
    wait_start |-> (acc_hit && $past(acc_done)));

  p_div_tick_r10: assert property (@(posedge clk) disable iff (!rst_bkd_n)
    (div_pulse && rtc_en_o && rtc_src_o == 2'b11) |=> rtc_tick_o);

  p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_bkd_n)
    rtc_tick_o |-> $past(rtc_en_o));
endmodule

bind bkd_ctrl bkd_ctrl_chk u_chk (
  .clk        (clk),
  .rst_sys_n  (rst_sys_n),
  .rst_bkd_n  (rst_bkd_n),
  .wp_release (wp_release),
  .bus_ready  (bus_ready),
  .acc_hit    (acc_hit),
  .acc_done   (acc_done),
  .wait_start (wait_start),
  .div_pulse  (div_pulse),
  .bus_rdata  (bus_rdata),
  .osc_en_o   (osc_en_o),
  .osc_byp_o  (osc_byp_o),
  .rtc_src_o  (rtc_src_o),
  .rtc_en_o   (rtc_en_o),
  .dom_rst_o  (dom_rst_o),
  .rtc_tick_o (rtc_tick_o)
);

// File: tb/bkd_ctrl_tb.sv
`timescale 1ns/1ps
module bkd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_sys_n, rst_bkd_n;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        wp_release, osc_rdy_in;
  logic        hs_tick_in, ls_ext_tick_in, ls_int_tick_in;
  logic        osc_en_o, osc_byp_o, rtc_en_o, dom_rst_o, rtc_tick_o;
  logic [1:0]  rtc_src_o;

  always #4 clk = ~clk;

  bkd_ctrl u_dut (
    .clk(clk), .rst_sys_n(rst_sys_n), .rst_bkd_n(rst_bkd_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .wp_release(wp_release), .osc_rdy_in(osc_rdy_in),
    .hs_tick_in(hs_tick_in), .ls_ext_tick_in(ls_ext_tick_in),
    .ls_int_tick_in(ls_int_tick_in), .osc_en_o(osc_en_o), .osc_byp_o(osc_byp_o),
    .rtc_src_o(rtc_src_o), .rtc_en_o(rtc_en_o), .dom_rst_o(dom_rst_o),
    .rtc_tick_o(rtc_tick_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // Reference state of the register, kept from the requirements alone.
  bit       m_en, m_byp, m_rtcen, m_rst, rdy_lvl, last_hit;
  bit [1:0] m_src;

  function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [31:0] m_image();
    return {15'b0, m_rst, m_rtcen, 5'b0, m_src, 5'b0, m_byp, m_en & rdy_lvl, m_en};
  endfunction

  function automatic void m_write(input logic [31:0] d, input logic [3:0] be, input bit wp);
    if (!m_rst) begin
      if (be[0] && wp) begin
        if (!m_en) m_byp = d[2];
        m_en = d[0];
      end
      if (be[1] && wp) begin
        m_rtcen = d[15];
        if (m_src == 2'b00) m_src = d[9:8];
      end
    end
    if (be[2]) m_rst = d[16];
    if (m_rst) begin
      m_en = 0; m_byp = 0; m_rtcen = 0; m_src = 2'b00;
    end
  endfunction

  function automatic void m_clear();
    m_en = 0; m_byp = 0; m_rtcen = 0; m_rst = 0; m_src = 2'b00;
  endfunction

  task automatic check_outs(input string tag);
    chk({tag, " osc_en"}, 32'(osc_en_o), 32'(m_en));
    chk({tag, " bypass"}, 32'(osc_byp_o), 32'(m_byp));
    chk({tag, " src"}, 32'(rtc_src_o), 32'(m_src));
    chk({tag, " rtc_en"}, 32'(rtc_en_o), 32'(m_rtcen));
    chk({tag, " dom_rst"}, 32'(dom_rst_o), 32'(m_rst));
  endtask

  task automatic do_op(input bit wr, input logic [7:0] addr, input logic [31:0] d,
                       input logic [3:0] be, input bit wp, input bit gap,
                       output logic [31:0] rd_o);
    bit          hit;
    int          exp_w;
    int          waits;
    logic [31:0] exp_rd;
    if (gap) begin
      @(negedge clk); bus_sel = 0; bus_wr = 0;
      @(negedge clk); check_outs("R3/R6 outputs");
      last_hit = 0;
    end
    hit    = (addr[7:2] == 6'h08);
    exp_w  = (hit && last_hit) ? 2 : 0;
    exp_rd = hit ? m_image() : 32'h0;
    @(negedge clk);
    bus_sel = 1; bus_wr = wr; bus_addr = addr; bus_wdata = d; bus_be = be; wp_release = wp;
    waits = 0;
    #1;
    while (!bus_ready && waits < 20) begin
      @(negedge clk); #1; waits++;
    end
    rd_o = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
    chk("R8 wait cycles", 32'(waits), 32'(exp_w));
    if (!wr) chk("R2 read image", rd_o, exp_rd);
    if (hit && wr) m_write(d, be, wp);
    last_hit = hit;
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  logic [31:0] rd, d;
  logic [3:0]  be;
  logic [7:0]  addr;
  bit          wr, wp, gap, force_gap, prev_rst, exp_tick;
  int          ntick, last_k;

  initial begin : main
    void'($urandom(32'd20240611));
    rst_sys_n = 0; rst_bkd_n = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = 8'h20; bus_wdata = 0; bus_be = 0;
    wp_release = 0; osc_rdy_in = 0; rdy_lvl = 0;
    hs_tick_in = 0; ls_ext_tick_in = 0; ls_int_tick_in = 0;
    m_clear(); last_hit = 0;
    repeat (3) @(negedge clk);
    rst_sys_n = 1; rst_bkd_n = 1;
    @(negedge clk);

    // R1: reset state
    check_outs("R1 reset");
    do_op(0, 8'h20, 0, 4'hF, 0, 1, rd);
    chk("R1 reset read", rd, 32'h0);

    // R3: writes blocked while protection is active
    do_op(1, 8'h20, 32'h0000_8305, 4'hF, 0, 1, rd);
    do_op(0, 8'h20, 0, 4'hF, 0, 0, rd);
    chk("R3 protected write ignored", rd, 32'h0);

    // R5: bypass writable only while oscillator off
    do_op(1, 8'h20, 32'h1, 4'h1, 1, 1, rd);
    do_op(1, 8'h20, 32'h5, 4'h1, 1, 0, rd);
    do_op(0, 8'h20, 0, 4'hF, 1, 0, rd);
    chk("R5 bypass blocked while on", 32'(rd[2]), 32'h0);
    do_op(1, 8'h20, 32'h0, 4'h1, 1, 1, rd);
    do_op(1, 8'h20, 32'h4, 4'h1, 1, 0, rd);
    do_op(0, 8'h20, 0, 4'hF, 1, 0, rd);
    chk("R5 bypass taken while off", 32'(rd[2]), 32'h1);

    // R4: source select written once
    do_op(1, 8'h20, 32'h0000_0200, 4'h2, 1, 1, rd);
    do_op(1, 8'h20, 32'h0000_8100, 4'h2, 1, 0, rd);
    do_op(0, 8'h20, 0, 4'hF, 1, 0, rd);
    chk("R4 source locked", 32'(rd[9:8]), 32'h2);
    chk("R4 rtc enable still writable", 32'(rd[15]), 32'h1);

    // R9: lane enables
    do_op(1, 8'h20, 32'h0000_0000, 4'h1, 1, 1, rd);
    do_op(1, 8'h21, 32'hFFFF_FFFF, 4'h0, 1, 0, rd);
    do_op(0, 8'h20, 0, 4'hF, 1, 0, rd);
    chk("R9 lane1 untouched by lane0 write", 32'(rd[15]), 32'h1);
    chk("R9 lane0 cleared", 32'(rd[2:0]), 32'h0);

    // R7: synchronizer latency and gating
    do_op(1, 8'h20, 32'h1, 4'h1, 1, 1, rd);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 8'h20; bus_be = 4'hF; osc_rdy_in = 1;
    @(negedge clk);
    chk("R7 flag low one cycle after input", 32'(bus_rdata[1]), 32'h0);
    @(negedge clk);
    chk("R7 flag high two cycles after input", 32'(bus_rdata[1]), 32'h1);
    bus_sel = 0; rdy_lvl = 1; last_hit = 0;
    repeat (2) @(negedge clk);
    do_op(1, 8'h20, 32'h2, 4'h1, 1, 1, rd);
    do_op(0, 8'h20, 0, 4'hF, 1, 0, rd);
    chk("R7 flag gated by enable", 32'(rd[1]), 32'h0);
    do_op(1, 8'h20, 32'h1, 4'h1, 1, 1, rd);

    // R10: internal low-speed source, external ignored
    exp_tick = 0;
    for (int k = 0; k <= 30; k++) begin
      @(negedge clk);
      if (k > 0) chk("R10 internal tick follows", 32'(rtc_tick_o), 32'(exp_tick));
      ls_int_tick_in = (k < 30) && (k % 3 == 0);
      ls_ext_tick_in = (k < 30);
      exp_tick = m_rtcen && ls_int_tick_in && (m_src == 2'b10);
    end
    // R11: gate closed
    do_op(1, 8'h20, 32'h0, 4'h2, 1, 1, rd);
    for (int k = 0; k <= 20; k++) begin
      @(negedge clk);
      if (k > 0) chk("R11 tick gated off", 32'(rtc_tick_o), 32'h0);
      ls_int_tick_in = (k < 20);
    end

    // R6: software domain reset
    do_op(1, 8'h20, 32'h0001_0000, 4'h4, 0, 1, rd);
    do_op(0, 8'h20, 0, 4'hF, 0, 1, rd);
    chk("R6 reset bit reads set", 32'(rd[16]), 32'h1);
    do_op(1, 8'h20, 32'h0001_8301, 4'hF, 1, 0, rd);
    do_op(0, 8'h20, 0, 4'hF, 1, 1, rd);
    chk("R6 fields held clear", rd & 32'h0000_8305, 32'h0);
    do_op(1, 8'h20, 32'h0, 4'h4, 0, 0, rd);
    do_op(0, 8'h20, 0, 4'hF, 0, 1, rd);
    chk("R6 reset bit cleared", 32'(rd[16]), 32'h0);

    // R10: divide-by-128 path
    do_op(1, 8'h20, 32'h0000_8300, 4'h2, 1, 1, rd);
    @(negedge clk);
    ntick = 0; last_k = -1;
    for (int k = 0; k <= 384; k++) begin
      @(negedge clk);
      if (k > 0 && rtc_tick_o) begin
        ntick++;
        if (last_k >= 0) chk("R10 divider spacing", 32'(k - last_k), 32'd128);
        last_k = k;
      end
      hs_tick_in = (k < 384);
    end
    chk("R10 divider count", 32'(ntick), 32'd3);

    // R1: system reset leaves fields alone
    do_op(1, 8'h20, 32'h1, 4'h1, 1, 1, rd);
    @(negedge clk); rst_sys_n = 0;
    repeat (2) @(negedge clk); rst_sys_n = 1;
    @(negedge clk);
    check_outs("R1 system reset keeps fields");
    last_hit = 0;

    // Random mix against the reference model
    force_gap = 0;
    for (int i = 0; i < 200; i++) begin
      wr   = $urandom % 2;
      addr = (($urandom % 8) == 0) ? 8'h24 : (8'h20 | 8'($urandom % 4));
      d    = $urandom;
      d[16] = m_rst ? ($urandom % 2) : (($urandom % 10) == 0);
      be   = 4'($urandom);
      wp   = ($urandom % 4) != 0;
      gap  = force_gap || (($urandom % 3) == 0);
      prev_rst = m_rst;
      do_op(wr, addr, d, be, wp, gap, rd);
      force_gap = !prev_rst && m_rst;
    end

    // R1: domain reset clears everything
    @(negedge clk); rst_bkd_n = 0;
    repeat (2) @(negedge clk); rst_bkd_n = 1;
    m_clear();
    @(negedge clk);
    check_outs("R1 domain reset");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule